// File: doc/BRIEF.md
# Coalesced Interrupt Acknowledge Tracker

This block follows the end-of-interrupt acknowledgments still owed for one edge-triggered interrupt line whose lost assertions have to be reported. The delivery logic picks the receivers of an interrupt. When it delivers one on this line, it gives the tracker two things: the set of receivers as a bitmap, and the number it reports as delivered. The tracker stores both. Each receiver then acknowledges by index, and the tracker clears that receiver's bit and lowers the count.

While any acknowledgment is still owed, `coalesced_o` is high. The delivery logic uses it to drop a new assertion on the line and report the assertion as lost. A delivery attempt made while acknowledgments are outstanding is refused and raises a one-cycle error pulse.

The state can be resynchronised from a vector of per-receiver "still pending" inputs. This can be done for one receiver at a time or for all receivers at once. The same full rebuild is used whenever a decrement would take the count below zero, or an increment would take it past its largest value.

Top module: `coalesce_eoi_tracker`

## Requirements
- R1: `coalesced_o` is high exactly while the pending count is nonzero. It follows the count in the same cycle that the count changes.
- R2: A delivery is accepted when `deliver_i` is high, `restore_all_i` is low and the count is zero. After the next edge, the count equals `deliver_cnt_i` and the bitmap equals `dest_map_i`.
- R3: When `deliver_i` is high, `restore_all_i` is low and the count is nonzero, the attempt changes no state. `deliver_err_o` is then high for the single cycle after that edge. `deliver_err_o` is low at every other time.
- R4: When `eoi_i` is high and bit `eoi_dest_i` of the bitmap is set, that bit is cleared and the count drops by one.
- R5: When `eoi_i` is high and bit `eoi_dest_i` is clear, or the index is out of range, neither the count nor the bitmap changes.
- R6: A decrement from a count of zero never wraps. Instead, the bitmap is loaded from `restore_pend_i` and the count is set to the number of ones in `restore_pend_i`. The same rebuild replaces an increment from the count's largest value, which is all ones.
- R7: Restore-one (`restore_one_i` with index `restore_dest_i`) compares `restore_pend_i[restore_dest_i]` with the stored bit for that receiver. If the input is 1 and the bit is 0, the bit is set and the count is incremented. If the input is 0 and the bit is 1, the bit is cleared and the count is decremented. If they are equal, nothing changes.
- R8: Restore-all (`restore_all_i`) loads the bitmap from `restore_pend_i` and sets the count to the number of ones in it.
- R9: At most one update is applied per cycle, in this order of priority: restore-all, then an accepted delivery, then an EOI (when `eoi_i` is high, restore-one is ignored), then restore-one.
- R10: Asserting `rst_ni` low clears the count, the bitmap and `deliver_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deliver_i | input | 1 | Delivery attempt on the tracked line |
| dest_map_i | input | N_DEST | Receivers of the delivery |
| deliver_cnt_i | input | CNT_W | Delivered count reported by the delivery logic |
| eoi_i | input | 1 | EOI event valid |
| eoi_dest_i | input | IDX_W | Receiver index of the EOI |
| restore_one_i | input | 1 | Resynchronise one receiver |
| restore_dest_i | input | IDX_W | Receiver index for restore-one |
| restore_all_i | input | 1 | Rebuild whole state |
| restore_pend_i | input | N_DEST | Per-receiver pending inputs |
| coalesced_o | output | 1 | Acknowledgments outstanding; drop new assertions |
| deliver_err_o | output | 1 | Delivery attempted while acknowledgments were outstanding |
| pend_cnt_o | output | CNT_W | Pending acknowledgment count |
| pend_map_o | output | N_DEST | Receivers still owing an acknowledgment |

## Verification
Every update is registered once, so an event presented before clock edge k shows on `pend_cnt_o` and `pend_map_o` after edge k. `coalesced_o` follows the count with no further delay, and `deliver_err_o` is high for exactly the cycle after edge k. The bench drives inputs at the falling edge and advances a behavioural model for each edge. At the next falling edge, one cycle after the stimulus, it compares all four outputs with the model. Directed phases cover each requirement in turn, including simultaneous events and the rebuild on an underflow, and a random phase follows them.

// File: rtl/cet_pkg.sv
package cet_pkg;
  typedef enum logic [2:0] {
    UPD_HOLD,
    UPD_REBUILD,
    UPD_LOAD,
    UPD_CLR,
    UPD_SET
  } upd_e;
endpackage

// File: rtl/cet_popcount.sv
module cet_popcount #(
  parameter int unsigned W  = 8,
  parameter int unsigned OW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic [OW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + OW'(vec_i[i]);
  end
endmodule

// File: rtl/cet_onehot.sv
module cet_onehot #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [IW-1:0] idx_i,
  output logic [N-1:0]  oh_o
);
  // out-of-range index decodes to all zeros
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign oh_o[g] = (idx_i == IW'(g));
  end
endmodule

// File: rtl/cet_next_state.sv
module cet_next_state
  import cet_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] cnt_q_i,
  input  logic [N-1:0]     map_q_i,
  input  logic             deliver_i,
  input  logic [N-1:0]     dest_map_i,
  input  logic [CNT_W-1:0] deliver_cnt_i,
  input  logic             eoi_i,
  input  logic [N-1:0]     eoi_oh_i,
  input  logic             restore_one_i,
  input  logic [N-1:0]     ro_oh_i,
  input  logic             restore_all_i,
  input  logic [N-1:0]     rp_i,
  input  logic [CNT_W-1:0] rp_cnt_i,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic [N-1:0]     map_d_o,
  output logic             err_d_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  upd_e        upd;
  logic        cnt_zero, accept, eoi_hit, ro_set, ro_clr;
  logic [N-1:0] sel;

  assign cnt_zero = (cnt_q_i == '0);
  assign accept   = deliver_i && cnt_zero;
  assign eoi_hit  = |(eoi_oh_i & map_q_i);
  assign ro_set   = |(ro_oh_i & rp_i & ~map_q_i);
  assign ro_clr   = |(ro_oh_i & ~rp_i & map_q_i);
  assign err_d_o  = deliver_i && !cnt_zero && !restore_all_i;

  always_comb begin
    upd = UPD_HOLD;
    sel = '0;
    if (restore_all_i) begin
      upd = UPD_REBUILD;
    end else if (accept) begin
      upd = UPD_LOAD;
    end else if (eoi_i) begin
      if (eoi_hit) begin
        upd = cnt_zero ? UPD_REBUILD : UPD_CLR;
        sel = eoi_oh_i;
      end
    end else if (restore_one_i) begin
      sel = ro_oh_i;
      if (ro_set)      upd = (cnt_q_i == CntMax) ? UPD_REBUILD : UPD_SET;
      else if (ro_clr) upd = cnt_zero ? UPD_REBUILD : UPD_CLR;
    end
  end

  always_comb begin
    cnt_d_o = cnt_q_i;
    map_d_o = map_q_i;
    unique case (upd)
      UPD_REBUILD: begin cnt_d_o = rp_cnt_i;      map_d_o = rp_i;           end
      UPD_LOAD:    begin cnt_d_o = deliver_cnt_i; map_d_o = dest_map_i;     end
      UPD_CLR:     begin cnt_d_o = cnt_q_i - 1'b1; map_d_o = map_q_i & ~sel; end
      UPD_SET:     begin cnt_d_o = cnt_q_i + 1'b1; map_d_o = map_q_i | sel;  end
      default: ;
    endcase
  end
endmodule

// File: rtl/coalesce_eoi_tracker.sv
module coalesce_eoi_tracker #(
  parameter int unsigned N_DEST = 8,
  parameter int unsigned CNT_W  = $clog2(N_DEST + 1),
  parameter int unsigned IDX_W  = (N_DEST > 1) ? $clog2(N_DEST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deliver_i,
  input  logic [N_DEST-1:0] dest_map_i,
  input  logic [CNT_W-1:0]  deliver_cnt_i,
  input  logic              eoi_i,
  input  logic [IDX_W-1:0]  eoi_dest_i,
  input  logic              restore_one_i,
  input  logic [IDX_W-1:0]  restore_dest_i,
  input  logic              restore_all_i,
  input  logic [N_DEST-1:0] restore_pend_i,
  output logic              coalesced_o,
  output logic              deliver_err_o,
  output logic [CNT_W-1:0]  pend_cnt_o,
  output logic [N_DEST-1:0] pend_map_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, rp_cnt;
  logic [N_DEST-1:0] map_q, map_d, eoi_oh, ro_oh;
  logic              err_q, err_d;

  cet_popcount #(.W(N_DEST), .OW(CNT_W)) u_rp_cnt (
    .vec_i(restore_pend_i), .cnt_o(rp_cnt)
  );

  cet_onehot #(.N(N_DEST), .IW(IDX_W)) u_eoi_dec (
    .idx_i(eoi_dest_i), .oh_o(eoi_oh)
  );

  cet_onehot #(.N(N_DEST), .IW(IDX_W)) u_ro_dec (
    .idx_i(restore_dest_i), .oh_o(ro_oh)
  );

  cet_next_state #(.N(N_DEST), .CNT_W(CNT_W)) u_next (
    .cnt_q_i      (cnt_q),
    .map_q_i      (map_q),
    .deliver_i    (deliver_i),
    .dest_map_i   (dest_map_i),
    .deliver_cnt_i(deliver_cnt_i),
    .eoi_i        (eoi_i),
    .eoi_oh_i     (eoi_oh),
    .restore_one_i(restore_one_i),
    .ro_oh_i      (ro_oh),
    .restore_all_i(restore_all_i),
    .rp_i         (restore_pend_i),
    .rp_cnt_i     (rp_cnt),
    .cnt_d_o      (cnt_d),
    .map_d_o      (map_d),
    .err_d_o      (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      map_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      map_q <= map_d;
      err_q <= err_d;
    end
  end

  assign coalesced_o   = (cnt_q != '0);
  assign deliver_err_o = err_q;
  assign pend_cnt_o    = cnt_q;
  assign pend_map_o    = map_q;
endmodule

// File: rtl/cet_checker.sv
module cet_checker #(
  parameter int unsigned N_DEST = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              deliver_i,
  input logic [N_DEST-1:0] dest_map_i,
  input logic [CNT_W-1:0]  deliver_cnt_i,
  input logic              eoi_i,
  input logic [IDX_W-1:0]  eoi_dest_i,
  input logic              restore_one_i,
  input logic              restore_all_i,
  input logic [N_DEST-1:0] restore_pend_i,
  input logic              coalesced_o,
  input logic              deliver_err_o,
  input logic [CNT_W-1:0]  pend_cnt_o,
  input logic [N_DEST-1:0] pend_map_o
);
  logic eoi_miss;
  assign eoi_miss = (32'(eoi_dest_i) >= N_DEST) || !pend_map_o[eoi_dest_i];

  p_hold_coalesced_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coalesced_o && !restore_all_i && !eoi_i && !restore_one_i) |=> coalesced_o);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_i && !restore_all_i && pend_cnt_o == '0) |=>
      (pend_cnt_o == $past(deliver_cnt_i) && pend_map_o == $past(dest_map_i)));

  p_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_i && !restore_all_i && pend_cnt_o != '0) |=> deliver_err_o);

  p_no_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deliver_i || restore_all_i || pend_cnt_o == '0) |=> !deliver_err_o);

  p_eoi_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && eoi_miss && !restore_all_i && !(deliver_i && pend_cnt_o == '0)) |=>
      ($stable(pend_cnt_o) && $stable(pend_map_o)));

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt_o == '0 && !deliver_i) |=> (32'(pend_cnt_o) <= N_DEST));

  p_restore_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_all_i |=> (pend_map_o == $past(restore_pend_i)));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r10: assert (pend_cnt_o == '0 && pend_map_o == '0 && !deliver_err_o);
    end
  end
endmodule

bind coalesce_eoi_tracker cet_checker #(
  .N_DEST(N_DEST), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_cet_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .deliver_i     (deliver_i),
  .dest_map_i    (dest_map_i),
  .deliver_cnt_i (deliver_cnt_i),
  .eoi_i         (eoi_i),
  .eoi_dest_i    (eoi_dest_i),
  .restore_one_i (restore_one_i),
  .restore_all_i (restore_all_i),
  .restore_pend_i(restore_pend_i),
  .coalesced_o   (coalesced_o),
  .deliver_err_o (deliver_err_o),
  .pend_cnt_o    (pend_cnt_o),
  .pend_map_o    (pend_map_o)
);

// File: tb/coalesce_eoi_tracker_bench.sv
`timescale 1ns/1ps
module coalesce_eoi_tracker_bench;
  localparam int N = 8;
  localparam int CW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic deliver_i = 0, eoi_i = 0, restore_one_i = 0, restore_all_i = 0;
  logic [N-1:0] dest_map_i = '0, restore_pend_i = '0;
  logic [CW-1:0] deliver_cnt_i = '0;
  logic [IW-1:0] eoi_dest_i = '0, restore_dest_i = '0;
  logic coalesced_o, deliver_err_o;
  logic [CW-1:0] pend_cnt_o;
  logic [N-1:0] pend_map_o;

  int checks = 0, fails = 0;
  string tag = "R10";
  int m_cnt = 0;
  logic [N-1:0] m_map = '0;
  bit m_err = 0;

  always #10 clk = ~clk;

  coalesce_eoi_tracker u_coalesce_eoi_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .deliver_i(deliver_i), .dest_map_i(dest_map_i),
    .deliver_cnt_i(deliver_cnt_i), .eoi_i(eoi_i), .eoi_dest_i(eoi_dest_i),
    .restore_one_i(restore_one_i), .restore_dest_i(restore_dest_i),
    .restore_all_i(restore_all_i), .restore_pend_i(restore_pend_i),
    .coalesced_o(coalesced_o), .deliver_err_o(deliver_err_o),
    .pend_cnt_o(pend_cnt_o), .pend_map_o(pend_map_o)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("count", int'(pend_cnt_o), m_cnt);
    chk("map", int'(pend_map_o), int'(m_map));
    chk("coalesced R1", int'(coalesced_o), int'(m_cnt != 0));
    chk("error R3", int'(deliver_err_o), int'(m_err));
  endtask

  // behavioural reference for one clock edge
  task automatic model_step();
    int pc;
    pc = $countones(restore_pend_i);
    m_err = deliver_i && !restore_all_i && m_cnt != 0;
    if (restore_all_i) begin
      m_map = restore_pend_i; m_cnt = pc;
    end else if (deliver_i && m_cnt == 0) begin
      m_map = dest_map_i; m_cnt = int'(deliver_cnt_i);
    end else if (eoi_i) begin
      if (m_map[eoi_dest_i]) begin
        if (m_cnt == 0) begin m_map = restore_pend_i; m_cnt = pc; end
        else begin m_map[eoi_dest_i] = 1'b0; m_cnt--; end
      end
    end else if (restore_one_i) begin
      if (restore_pend_i[restore_dest_i] && !m_map[restore_dest_i]) begin
        if (m_cnt == 15) begin m_map = restore_pend_i; m_cnt = pc; end
        else begin m_map[restore_dest_i] = 1'b1; m_cnt++; end
      end else if (!restore_pend_i[restore_dest_i] && m_map[restore_dest_i]) begin
        if (m_cnt == 0) begin m_map = restore_pend_i; m_cnt = pc; end
        else begin m_map[restore_dest_i] = 1'b0; m_cnt--; end
      end
    end
  endtask

  task automatic idle();
    deliver_i = 0; eoi_i = 0; restore_one_i = 0; restore_all_i = 0;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic do_reset();
    tag = "R10";
    @(negedge clk);
    rst_ni = 1'b0;
    m_cnt = 0; m_map = '0; m_err = 0;
    @(posedge clk);
    @(negedge clk);
    compare();
    rst_ni = 1'b1;
  endtask

  task automatic deliver(logic [N-1:0] m, int c);
    deliver_i = 1; dest_map_i = m; deliver_cnt_i = CW'(c); cyc();
  endtask

  task automatic eoi(int d, logic [N-1:0] rp);
    eoi_i = 1; eoi_dest_i = IW'(d); restore_pend_i = rp; cyc();
  endtask

  task automatic ro(int d, logic [N-1:0] rp);
    restore_one_i = 1; restore_dest_i = IW'(d); restore_pend_i = rp; cyc();
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    tag = "R2"; deliver(8'h2D, 4);
    tag = "R3"; deliver(8'hFF, 8);
    cyc();
    tag = "R5"; eoi(1, 8'h00);
    tag = "R4"; eoi(0, 8'h00);
    eoi(2, 8'h00); eoi(3, 8'h00);
    tag = "R1"; eoi(5, 8'h00);
    tag = "R2"; deliver(8'h03, 1);
    tag = "R4"; eoi(0, 8'h00);
    tag = "R6"; eoi(1, 8'h50);
    tag = "R7"; ro(4, 8'h10);
    ro(6, 8'h10);
    ro(0, 8'h11);
    ro(4, 8'h01);
    tag = "R6"; ro(0, 8'h0E);
    tag = "R9";
    restore_all_i = 1; deliver_i = 1; dest_map_i = 8'hAA; deliver_cnt_i = 4'd4;
    restore_pend_i = 8'hF0; cyc();
    tag = "R8"; restore_all_i = 1; restore_pend_i = 8'h00; cyc();
    tag = "R9";
    deliver_i = 1; dest_map_i = 8'h0F; deliver_cnt_i = 4'd4; eoi_i = 1; eoi_dest_i = 3'd0; cyc();
    eoi_i = 1; eoi_dest_i = 3'd6; restore_one_i = 1; restore_dest_i = 3'd6;
    restore_pend_i = 8'h40; cyc();
    deliver_i = 1; dest_map_i = 8'h0F; deliver_cnt_i = 4'd1; eoi_i = 1; eoi_dest_i = 3'd1; cyc();
    tag = "R8"; restore_all_i = 1; restore_pend_i = 8'hFF; cyc();
    tag = "R6"; restore_all_i = 1; restore_pend_i = 8'h00; cyc();
    deliver(8'h00, 15);
    ro(2, 8'h84);
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      deliver_i      = ($urandom_range(3) == 0);
      dest_map_i     = N'($urandom);
      deliver_cnt_i  = CW'($urandom_range(0, 9));
      eoi_i          = ($urandom_range(1) == 0);
      eoi_dest_i     = IW'($urandom);
      restore_one_i  = ($urandom_range(3) == 0);
      restore_dest_i = IW'($urandom);
      restore_all_i  = ($urandom_range(15) == 0);
      restore_pend_i = N'($urandom);
      cyc();
    end
    deliver(8'hC3, 4);
    deliver(8'h11, 2);
    do_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule